// File: doc/BRIEF.md
# MicroWire Serial Master

This block is a host-side master for a three-wire synchronous serial link with a separate active-low chip select. The host writes a transmit word and a configuration (word length and clock divider) over a simple register bus. It then issues commands that change the chip-select level and start a shift. The shift engine sends the configured number of bits, most significant first, and captures the same number of response bits. The captured word is handed back right-aligned, with a flag that shows it is waiting to be read.

The shift engine runs on its own reference clock, divided by a programmable factor, and is asynchronous to the host clock. Each command crosses into the engine domain as a toggle. Each completion crosses back as a second toggle, which clears the busy flag and, after a shift, delivers the received word. The host sets the busy flag in the same cycle that a command is accepted, so a status read never sees a stale idle value. While busy is set, the block ignores every write that would disturb the engine.

Register map (word address on `bus_addr`):
- 0: a write loads the transmit word; a read returns the receive word and clears the receive-full flag.
- 1: a write issues a command: bit 0 starts a shift, bit 1 requests a chip-select change, bit 2 is the requested level (1 drives `cs_n` low). A read returns status: bit 15 is receive-full, bit 14 is busy, bit 0 is the commanded chip-select level, and all other bits are 0.
- 2: configuration, which can be read and written. Bits [4:0] hold the word length (values above 16 are clamped to 16). Bits [15:8] hold the divider N.

Top module: `uwire_master`

## Requirements
- R1: A shift of length L (1..16) drives exactly L rising serial-clock edges. The data-out bits are transmit-word bits 15 down to 16-L, in that order.
- R2: After a shift of length L, the receive word holds the L sampled bits in its low L bits, with the last sampled bit in bit 0. Bits 15..L read as 0.
- R3: Receive-full (status bit 15) becomes 1 when a shift's receive word is delivered. A host read of address 0 clears it.
- R4: Busy (status bit 14) reads 1 in the host cycle after an accepted command write. It stays 1 until the engine reports completion, then returns to 0.
- R5: A command write with bit 1 set drives `cs_n` to the inverse of bit 2 once applied. Status bit 0 reports the commanded level.
- R6: The serial clock idles low. Data out changes only at falling edges and data in is sampled at rising edges. The serial clock stays low whenever `cs_n` is high, including during a shift.
- R7: Each serial-clock half period lasts N reference-clock cycles; N = 0 acts as 1.
- R8: A start command with a configured length of 0 does nothing: busy stays 0 and no serial-clock edge occurs.
- R9: While busy is 1, writes to the transmit, command and configuration registers are ignored.
- R10: After reset, busy and receive-full read 0, `cs_n` is 1, and `sclk` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ref_clk | input | 1 | Reference clock of the shift engine |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive-full at address 0) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the peripheral |
| sdi | input | 1 | Serial data from the peripheral |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench acts as the peripheral. It shifts out known response words at several lengths and divider settings, including lengths 1 and 16 and a divider of 0. A design that aligned the received word wrongly, or that kept stale high bits, would return a mismatched receive word. A design that miscounted bits would produce the wrong number of clock edges. The bench also writes new data, a new length and a start while a shift is running. A design that let these through would send the wrong bits or change the configuration read back afterwards. Finally, it shifts with chip select released, where a design that did not hold the clock low would show edges, and it issues a zero-length start, which a faulty design would treat as a real shift and raise busy.

// File: rtl/uwire_master.sv
module uwire_master #(
  parameter int DW   = 16,
  parameter int LW   = 5,
  parameter int DIVW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_clk,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          sdo,
  input  logic          sdi,
  output logic          cs_n
);

  localparam logic [LW-1:0] MAXLEN = LW'(DW);

  // host domain
  logic [DW-1:0]   tx_q, rx_q;
  logic [LW-1:0]   len_q;
  logic [DIVW-1:0] div_q;
  logic            busy_q, full_q, cs_lvl_q, req_tgl, cmd_start, cmd_cs;
  logic [2:0]      dn_s;

  // engine domain
  logic [2:0]      rq_s;
  logic            act, ph, sclk_q, cs_act, done_tgl;
  logic [DW-1:0]   sh, rsh, rx_word;
  logic [LW-1:0]   cnt;
  logic [DIVW-1:0] dcnt;

  wire done_pulse = dn_s[2] ^ dn_s[1];
  wire wr_tx  = bus_wr && bus_addr == 2'd0 && !busy_q;
  wire wr_cfg = bus_wr && bus_addr == 2'd2 && !busy_q;
  wire go     = bus_wdata[0] && len_q != '0;
  wire accept = bus_wr && bus_addr == 2'd1 && !busy_q && (go || bus_wdata[1]);
  wire [LW-1:0] len_in = (bus_wdata[LW-1:0] > MAXLEN) ? MAXLEN : bus_wdata[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0; rx_q <= '0; len_q <= '0; div_q <= '0;
      busy_q <= 1'b0; full_q <= 1'b0; cs_lvl_q <= 1'b0;
      req_tgl <= 1'b0; cmd_start <= 1'b0; cmd_cs <= 1'b0;
      dn_s <= '0;
    end else begin
      dn_s <= {dn_s[1:0], done_tgl};
      if (wr_tx) tx_q <= bus_wdata;
      if (wr_cfg) begin
        len_q <= len_in;
        div_q <= bus_wdata[8 +: DIVW];
      end
      if (accept) begin
        req_tgl   <= ~req_tgl;
        cmd_start <= go;
        cmd_cs    <= bus_wdata[1];
        if (bus_wdata[1]) cs_lvl_q <= bus_wdata[2];
        busy_q    <= 1'b1;
      end
      if (done_pulse) begin
        busy_q <= 1'b0;
        if (cmd_start) begin
          rx_q   <= rx_word;
          full_q <= 1'b1;
        end
      end else if (bus_rd && bus_addr == 2'd0) begin
        full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata = rx_q;
      2'd1: begin
        bus_rdata[DW-1] = full_q;
        bus_rdata[DW-2] = busy_q;
        bus_rdata[0]    = cs_lvl_q;
      end
      2'd2: begin
        bus_rdata[LW-1:0]   = len_q;
        bus_rdata[8 +: DIVW] = div_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  wire req_pulse = rq_s[2] ^ rq_s[1];
  wire [DIVW-1:0] div_lim = (div_q == '0) ? '0 : div_q - 1'b1;
  wire tick = act && dcnt == div_lim;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_s <= '0; act <= 1'b0; ph <= 1'b0; sclk_q <= 1'b0;
      cs_act <= 1'b0; done_tgl <= 1'b0;
      sh <= '0; rsh <= '0; rx_word <= '0; cnt <= '0; dcnt <= '0;
    end else begin
      rq_s <= {rq_s[1:0], req_tgl};
      dcnt <= (!act || tick) ? '0 : dcnt + 1'b1;
      if (req_pulse) begin
        if (cmd_cs) cs_act <= cs_lvl_q;
        if (cmd_start) begin
          act <= 1'b1; ph <= 1'b0; sclk_q <= 1'b0;
          sh <= tx_q; rsh <= '0; cnt <= len_q;
        end else begin
          done_tgl <= ~done_tgl;
        end
      end else if (tick) begin
        if (!ph) begin
          sclk_q <= 1'b1;
          rsh    <= {rsh[DW-2:0], sdi};
          ph     <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          ph     <= 1'b0;
          sh     <= sh << 1;
          cnt    <= cnt - 1'b1;
          if (cnt == LW'(1)) begin
            act      <= 1'b0;
            rx_word  <= rsh;
            done_tgl <= ~done_tgl;
          end
        end
      end
    end
  end

  assign sdo  = act & sh[DW-1];
  assign sclk = sclk_q & cs_act;
  assign cs_n = ~cs_act;

  assert_full_from_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(done_pulse));
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && !done_pulse) |=> !full_q);
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_pulse) |=> busy_q);
  assert_busy_ignores_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr) |=> ($stable(tx_q) && $stable(len_q) && $stable(div_q) && $stable(cs_lvl_q)));
  assert_sclk_only_active_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sclk_q |-> act);
  assert_count_bound_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
    act |-> (cnt != '0 && cnt <= MAXLEN));

endmodule

// File: tb/uwire_master_tb.sv
`timescale 1ns/1ps
module uwire_master_tb;
  localparam int REFP = 41;

  logic clk = 0, ref_clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, sdi = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic sclk, sdo, cs_n;

  int n_chk = 0, n_fail = 0;
  int edges = 0, xlen = 0, sidx = 0;
  logic in_xfer = 0;
  logic [15:0] mosi_got = 0, resp = 0;
  longint t_rise = 0, hi_ns = 0;

  always #2.5 clk = ~clk;
  always #(REFP/2.0) ref_clk = ~ref_clk;

  uwire_master u_dut (.clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_n(cs_n));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // peripheral model
  always @(posedge sclk) begin
    mosi_got = {mosi_got[14:0], sdo};
    edges++;
    t_rise = $time;
    if (edges >= xlen) in_xfer = 0;
  end
  always @(negedge sclk) begin
    hi_ns = $time - t_rise;
    sidx--;
    sdi = (sidx >= 0) ? resp[sidx] : 1'b0;
  end

  // per-clock model comparison
  always @(negedge clk) if (rst_n) begin
    n_chk++;
    if (cs_n && sclk) begin n_fail++; $display("FAIL R6 sclk=%0b expected 0 with cs_n high", sclk); end
    n_chk++;
    if (in_xfer && !u_dut.bus_rdata[14] && bus_addr == 2'd1) begin
      n_fail++; $display("FAIL R4 busy=0 expected 1 mid-shift");
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd1, s);
      if (!s[14]) return;
    end
    check(0, "R4 busy never cleared", 1, 0);
  endtask

  task automatic xfer(input int len, input logic [15:0] tx, input logic [15:0] rsp, input int dv);
    logic [15:0] s, r;
    int mask, expo, n;
    wr(2'd2, {dv[7:0], 3'b0, len[4:0]});
    resp = rsp; sidx = len - 1; sdi = rsp[len-1]; edges = 0; mosi_got = 0; xlen = len;
    wr(2'd0, tx);
    wr(2'd1, 16'h0001);
    in_xfer = 1;
    rd(2'd1, s);
    check(s[14] == 1'b1, "R4 busy after start", s[14], 1);
    wait_idle();
    mask = (1 << len) - 1;
    expo = int'(tx) >> (16 - len);
    check(edges == len, "R1 edge count", edges, len);
    check((int'(mosi_got) & mask) == expo, "R1 data out order", int'(mosi_got) & mask, expo);
    n = (dv == 0) ? 1 : dv;
    check(hi_ns == longint'(n * REFP), "R7 half period", int'(hi_ns), n * REFP);
    rd(2'd1, s);
    check(s[15] == 1'b1, "R3 full set", s[15], 1);
    rd(2'd0, r);
    check(r == (rsp & 16'(mask)), "R2 receive alignment", r, rsp & 16'(mask));
    rd(2'd1, s);
    check(s[15] == 1'b0, "R3 full cleared by read", s[15], 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] s, r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rd(2'd1, s);
    check(s == 16'h0000, "R10 status after reset", s, 0);
    check(cs_n == 1'b1 && sclk == 1'b0 && sdo == 1'b0, "R10 pins after reset", {cs_n, sclk, sdo}, 3'b100);

    wr(2'd1, 16'h0006);
    rd(2'd1, s);
    check(s[14] == 1'b1, "R4 busy after cs command", s[14], 1);
    wait_idle();
    check(cs_n == 1'b0, "R5 cs asserted", cs_n, 0);
    rd(2'd1, s);
    check(s[0] == 1'b1, "R5 status cs level", s[0], 1);

    xfer(16, 16'hA5C3, 16'h3C96, 1);
    xfer(8,  16'hB700, 16'h005A, 3);
    xfer(1,  16'h8000, 16'h0001, 0);
    xfer(5,  16'h6800, 16'h0013, 2);
    xfer(16, 16'hFFFF, 16'h0000, 1);
    xfer(12, 16'h1234, 16'hFABC, 2);

    // R8 zero length
    wr(2'd2, 16'h0100);
    edges = 0;
    wr(2'd1, 16'h0001);
    rd(2'd1, s);
    check(s[14] == 1'b0, "R8 busy stays low", s[14], 0);
    repeat (100) @(negedge clk);
    check(edges == 0, "R8 no clock edges", edges, 0);
    rd(2'd1, s);
    check(s[15] == 1'b0, "R8 full unchanged", s[15], 0);

    // R9 writes while busy
    wr(2'd2, 16'h0408);
    resp = 16'h00C3; sidx = 7; sdi = resp[7]; edges = 0; mosi_got = 0; xlen = 8;
    wr(2'd0, 16'h1200);
    wr(2'd1, 16'h0001);
    in_xfer = 1;
    wr(2'd0, 16'hFF00);
    wr(2'd2, 16'h0110);
    wr(2'd1, 16'h0003);
    wait_idle();
    check(edges == 8, "R9 edge count unchanged", edges, 8);
    check(mosi_got[7:0] == 8'h12, "R9 transmit word kept", mosi_got[7:0], 8'h12);
    rd(2'd2, r);
    check(r == 16'h0408, "R9 config kept", r, 16'h0408);
    check(cs_n == 1'b0, "R9 cs level kept", cs_n, 0);
    rd(2'd0, r);
    check(r == 16'h00C3, "R2 receive after ignored writes", r, 16'h00C3);

    // R6 shift with chip select released
    wr(2'd1, 16'h0002);
    wait_idle();
    check(cs_n == 1'b1, "R5 cs released", cs_n, 1);
    edges = 0;
    wr(2'd1, 16'h0001);
    wait_idle();
    check(edges == 0, "R6 no clock while cs high", edges, 0);
    check(sclk == 1'b0, "R6 clock idles low", sclk, 0);
    rd(2'd1, s);
    check(s[15] == 1'b1, "R3 full after released shift", s[15], 1);
    rd(2'd0, r);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule